// File: doc/BRIEF.md
# Sub-Addressed I2C Register Target

This block is an I2C target that exposes a bank of 8-bit registers to a bus master. It answers one fixed 7-bit device address and acknowledges each byte it accepts. The byte after the address is a sub-address. Its low seven bits select a register. Its top bit picks the kind of access, independently of the R/W bit carried in the address byte.

A register write fits in one transaction: address with write bit, sub-address with top bit clear, one data byte, then STOP. A register read takes two phases. The master sends the address with the write bit and a sub-address with the top bit set. It then issues a repeated START and the address with the read bit, and clocks one byte out of the target, most significant bit first. The register bank sits outside the block. The block drives an address, write data and one-cycle strobes to the bank and takes read data back. Both bus lines are brought in through a synchronizer, and the block drives SDA only through an open-drain enable.

Top module: `i2c_subaddr_target`

## Requirements
- R1: An address byte whose upper seven bits equal 7'h54 is acknowledged. Any other address gets no acknowledge, and the target ignores all bytes until the next START.
- R2: Every byte the target accepts (a matching address, a sub-address, the first write data byte) is acknowledged by holding SDA low (sda_oe=1) for the ninth SCL clock.
- R3: A sub-address with bit 7 = 0 followed by a data byte produces exactly one reg_we pulse of one clock cycle. During that pulse reg_addr equals sub-address bits 6:0 and reg_wdata equals the data byte.
- R4: A sub-address with bit 7 = 1, then a repeated START and the address with R/W = 1, makes the target return reg_rdata for reg_addr = sub-address bits 6:0, MSB first. The target raises reg_re for one cycle when it accepts the read address.
- R5: A data byte that follows a sub-address with bit 7 = 1 in the same write transaction is not acknowledged and causes no reg_we.
- R6: An address with R/W = 1 is not acknowledged unless a sub-address with bit 7 = 1 was accepted earlier in the same transaction. A STOP discards that read setup.
- R7: Only one data byte is taken per write. A second data byte before STOP is not acknowledged and causes no further reg_we.
- R8: SDA is released on STOP. The target changes its SDA drive only just after a falling SCL edge.
- R9: While rst_n is low, sda_oe, reg_we and reg_re are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 7 | Register index from the sub-address |
| reg_wdata | output | 8 | Write data to the register bank |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read strobe |
| reg_rdata | input | 8 | Register bank read data for reg_addr |

## Verification
The bench sweeps all 128 device addresses. A decoder comparing the wrong bits, or counting the R/W bit as part of the address, would acknowledge a neighbour or miss 7'h54. It writes every register and reads back every fourth one against an arithmetic pattern. A target shifting read data one bit late, or latching the wrong sub-address bits, would return rotated values or alias registers. It also goes after the transactions that differ only in the sub-address direction bit: write data after a read setup, a read address with no setup or with a STOP in between, and a second write data byte. A design that confused the two direction bits would store a byte, acknowledge a bare read, or write twice.

// File: rtl/i2c_sat_pkg.sv
`timescale 1ns/1ps
// Shared types for the sub-addressed I2C target.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package i2c_sat_pkg;

    // Protocol phase of the target
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_RDATA
    } tgt_state_e;

    // Single-cycle bus events derived from the synchronized lines
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/i2c_sat_sync.sv
`timescale 1ns/1ps
// Line synchronizer and bus event detector.
// Brings SCL and SDA through SYNC_STAGES flops, then compares each line
// with its previous synchronized value to flag SCL edges and START/STOP.
// Assumes: SYNC_STAGES >= 2; both lines idle high; clk well above SCL rate.
module i2c_sat_sync
    import i2c_sat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Shift raw lines into the synchronizer chains and keep last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Decode edges and framing conditions from current and previous levels
    always_comb begin
        evt.scl_rise = scl_s & ~scl_prev;
        evt.scl_fall = ~scl_s & scl_prev;
        evt.start    = scl_s & scl_prev & sda_prev & ~sda_s;
        evt.stop     = scl_s & scl_prev & ~sda_prev & sda_s;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_sat_rx.sv
`timescale 1ns/1ps
// Receive shifter: collects BYTE_W bits MSB first on sample strobes.
// full is raised once BYTE_W bits are in; further samples are ignored
// until clear. clear wins over sample.
// Assumes: sample is a single-cycle strobe at the SCL rising edge.
module i2c_sat_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_q,
    output logic              full
);

    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic [CNT_W-1:0] bit_cnt;

    assign full = (bit_cnt == CNT_W'(BYTE_W));

    // Shift one bit in per sample until the byte is complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q  <= '0;
            bit_cnt <= '0;
        end else if (clear) begin
            bit_cnt <= '0;
        end else if (sample && !full) begin
            byte_q  <= {byte_q[BYTE_W-2:0], bit_in};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_subaddr_target.sv
`timescale 1ns/1ps
// I2C target with a sub-address whose top bit selects write or read setup.
// Write: addr+W, sub(b7=0), data -> one reg_we strobe.
// Read : addr+W, sub(b7=1), Sr, addr+R -> one byte from reg_rdata.
// Assumes: clk at least 8x SCL; no clock stretching; reg_rdata valid for
// reg_addr by the SCL falling edge that ends the read address ACK.
module i2c_subaddr_target
    import i2c_sat_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h54,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       reg_re,
    input  logic [7:0] reg_rdata
);

    localparam int BYTE_W = 8;
    localparam int IDX_W  = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    bus_evt_t          evt;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_full;
    logic              rx_clear;
    logic              rx_sample;
    logic              rx_phase;
    logic              addr_hit;

    tgt_state_e        state;
    tgt_state_e        pend_state;
    logic              in_ack;
    logic              armed;
    logic [BYTE_W-1:0] tx_sr;
    logic [CNT_W-1:0]  tx_cnt;
    logic [IDX_W-1:0]  ptr_q;
    logic [BYTE_W-1:0] wdata_q;

    i2c_sat_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_sat_rx #(
        .BYTE_W (BYTE_W)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (rx_clear),
        .sample (rx_sample),
        .bit_in (evt.sda),
        .byte_q (rx_byte),
        .full   (rx_full)
    );

    // Receive-side control: which phases shift bits and when to restart
    always_comb begin
        rx_phase  = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_WDATA);
        rx_sample = evt.scl_rise & ~in_ack & rx_phase;
        rx_clear  = evt.start | evt.stop | (evt.scl_fall & in_ack);
        addr_hit  = (rx_byte[BYTE_W-1:1] == DEV_ADDR);
    end

    assign reg_addr  = ptr_q;
    assign reg_wdata = wdata_q;

    // Protocol sequencer: ACK decisions, register strobes, read shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pend_state <= ST_IDLE;
            in_ack     <= 1'b0;
            armed      <= 1'b0;
            tx_sr      <= '0;
            tx_cnt     <= '0;
            ptr_q      <= '0;
            wdata_q    <= '0;
            sda_oe     <= 1'b0;
            reg_we     <= 1'b0;
            reg_re     <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
                armed  <= 1'b0;
            end else if (evt.scl_fall && in_ack) begin
                in_ack <= 1'b0;
                state  <= pend_state;
                if (pend_state == ST_RDATA) begin
                    tx_sr  <= reg_rdata;
                    tx_cnt <= '0;
                    sda_oe <= ~reg_rdata[BYTE_W-1];
                end else begin
                    sda_oe <= 1'b0;
                end
            end else if (evt.scl_fall) begin
                unique case (state)
                    ST_ADDR: begin
                        if (rx_full) begin
                            if (addr_hit && !rx_byte[0]) begin
                                in_ack     <= 1'b1;
                                sda_oe     <= 1'b1;
                                pend_state <= ST_SUB;
                            end else if (addr_hit && armed) begin
                                in_ack     <= 1'b1;
                                sda_oe     <= 1'b1;
                                pend_state <= ST_RDATA;
                                reg_re     <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_SUB: begin
                        if (rx_full) begin
                            in_ack     <= 1'b1;
                            sda_oe     <= 1'b1;
                            ptr_q      <= rx_byte[IDX_W-1:0];
                            armed      <= rx_byte[BYTE_W-1];
                            pend_state <= ST_WDATA;
                        end
                    end
                    ST_WDATA: begin
                        if (rx_full) begin
                            if (armed) begin
                                armed <= 1'b0;
                                state <= ST_IDLE;
                            end else begin
                                in_ack     <= 1'b1;
                                sda_oe     <= 1'b1;
                                wdata_q    <= rx_byte;
                                reg_we     <= 1'b1;
                                pend_state <= ST_IDLE;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (tx_cnt == CNT_W'(BYTE_W)) begin
                            sda_oe <= 1'b0;
                            armed  <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_sr[BYTE_W-2];
                        end
                    end
                    default: ;
                endcase
            end else if (evt.scl_rise && state == ST_RDATA && !in_ack) begin
                tx_cnt <= tx_cnt + 1'b1;
            end
        end
    end

endmodule

// Protocol checker for the I2C target, attached by bind below.
// Assumes: inputs are the target's ports and its decoded bus events.
module i2c_sat_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_fall,
    input logic start,
    input logic stop,
    input logic sda_oe,
    input logic reg_we,
    input logic reg_re
);

    // R3: write strobe lasts one cycle
    p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R3: write strobe only right after a falling SCL edge
    p_we_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(scl_fall));

    // R4: read strobe lasts one cycle
    p_re_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R3/R4: never read and write in the same cycle
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    // R8: STOP leaves SDA released
    p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_oe);

    // R8: drive changes only after SCL falls or on framing events
    p_drive_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(scl_fall) && !$past(start) && !$past(stop)) |-> $stable(sda_oe));

endmodule

bind i2c_subaddr_target i2c_sat_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_fall (evt.scl_fall),
    .start    (evt.start),
    .stop     (evt.stop),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_re   (reg_re)
);

// File: tb/tb_i2c_subaddr_target.sv
`timescale 1ns/1ps
// Bench: bus-level master model driving the target, with a bench-side
// register bank; expected data computed from an arithmetic pattern.
module tb_i2c_subaddr_target;

    localparam int         Q    = 5;      // clk cycles per SCL quarter
    localparam logic [6:0] DEV  = 7'h54;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic       reg_re;
    logic [7:0] reg_rdata;

    logic [7:0] bank [128];
    int         we_cnt = 0;
    int         re_cnt = 0;
    logic [6:0] last_we_addr = '0;
    logic [7:0] last_we_data = '0;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = bank[reg_addr];

    i2c_subaddr_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

    // Bench register bank and strobe counters
    always @(posedge clk) begin
        if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            we_cnt         <= we_cnt + 1;
            last_we_addr   <= reg_addr;
            last_we_data   <= reg_wdata;
        end
        if (reg_re) re_cnt <= re_cnt + 1;
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 91) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw(); qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw();
            m_scl = 1'b1; qw(); qw();
            m_scl = 1'b0;
        end
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        acked = ~sda_line;
        qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit m_ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; qw();
            m_scl = 1'b1; qw();
            b[i] = sda_line;
            qw();
            m_scl = 1'b0;
        end
        m_sda = ~m_ack; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic do_write(input logic [6:0] sub, input logic [7:0] d,
                            output bit a0, output bit a1, output bit a2);
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte({1'b0, sub}, a1);
        send_byte(d, a2);
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] sub, output logic [7:0] d,
                           output bit a0, output bit a1, output bit a2);
        d = 8'h00;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte({1'b1, sub}, a1);
        bus_rstart();
        send_byte({DEV, 1'b1}, a2);
        if (a2) recv_byte(d, 1'b0);
        bus_stop();
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a0, a1, a2, a3;
        logic [7:0] rd;
        int wc;

        for (int i = 0; i < 128; i++) bank[i] = 8'hEE;

        // R9: outputs quiet in reset
        repeat (6) @(negedge clk);
        chk(!sda_oe && !reg_we && !reg_re, "R9 reset outputs", {sda_oe, reg_we, reg_re}, 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1: address sweep, only 7'h54 acknowledged, nothing written
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, a0);
            bus_stop();
            chk(a0 == (a == 32'h54), "R1 address match", a0, (a == 32'h54));
        end
        chk(we_cnt == 0, "R1 no write in sweep", we_cnt, 0);

        // R1: mismatched target ignores following bytes
        bus_start();
        send_byte({7'h55, 1'b0}, a0);
        send_byte(8'h03, a1);
        send_byte(8'h77, a2);
        bus_stop();
        chk(!a0 && !a1 && !a2 && we_cnt == 0, "R1 ignore after mismatch", {a0, a1, a2}, 0);

        // R2/R3: write every register with the pattern
        for (int a = 0; a < 128; a++) begin
            wc = we_cnt;
            do_write(7'(a), pat(a), a0, a1, a2);
            chk(a0 && a1 && a2, "R2 write acks", {a0, a1, a2}, 7);
            chk(we_cnt == wc + 1, "R3 one write strobe", we_cnt - wc, 1);
            chk(last_we_addr == 7'(a) && last_we_data == pat(a), "R3 write addr/data",
                {last_we_addr, last_we_data}, {7'(a), pat(a)});
            chk(sda_line == 1'b1, "R8 released after stop", sda_line, 1);
        end

        // R4: read back every fourth register
        for (int a = 0; a < 128; a += 4) begin
            wc = re_cnt;
            do_read(7'(a), rd, a0, a1, a2);
            chk(a0 && a1 && a2, "R2 read acks", {a0, a1, a2}, 7);
            chk(rd == pat(a), "R4 read data", rd, pat(a));
            chk(re_cnt == wc + 1, "R4 one read strobe", re_cnt - wc, 1);
        end

        // R5: data after read setup in a write is refused
        wc = we_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h85, a1);
        send_byte(8'hAA, a2);
        bus_stop();
        chk(a0 && a1 && !a2, "R5 data NACK after read setup", {a0, a1, a2}, 6);
        chk(we_cnt == wc, "R5 no write", we_cnt - wc, 0);
        do_read(7'h05, rd, a0, a1, a2);
        chk(rd == pat(5), "R5 register unchanged", rd, pat(5));

        // R6: read address with no setup
        bus_start();
        send_byte({DEV, 1'b1}, a0);
        bus_stop();
        chk(!a0, "R6 read without setup NACK", a0, 0);

        // R6: STOP between setup and read address discards setup
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h90, a1);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b1}, a2);
        bus_stop();
        chk(a0 && a1 && !a2, "R6 setup lost on STOP", {a0, a1, a2}, 6);

        // R7: second data byte refused, single write
        wc = we_cnt;
        bus_start();
        send_byte({DEV, 1'b0}, a0);
        send_byte(8'h10, a1);
        send_byte(8'h3C, a2);
        send_byte(8'hC3, a3);
        bus_stop();
        chk(a0 && a1 && a2 && !a3, "R7 second byte NACK", {a0, a1, a2, a3}, 14);
        chk(we_cnt == wc + 1, "R7 single write", we_cnt - wc, 1);
        do_read(7'h10, rd, a0, a1, a2);
        chk(rd == 8'h3C, "R7 first byte kept", rd, 8'h3C);
        chk(sda_line == 1'b1 && !sda_oe, "R8 idle after stop", sda_oe, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule